// File: doc/BRIEF.md
# Erased Sector Zero-Bit Detector

This block runs after a sector decoder has given up on a sector, reporting more bit errors than it can repair. A freshly erased flash sector reads back as all-ones in both its data and its stored check bytes, yet all-ones check bytes are not the code word of all-ones data, so such a sector always fails decoding. The block tells this harmless case apart from real damage. It takes the data field and then the check field as a byte stream, one byte per accepted beat. For each field it keeps a count of the bits that read as zero, and that count stops climbing just above the correction limit.

When both fields have arrived, the block adds the two counts. If the sum is within the correction limit, the sector counts as erased. The reported number of corrected bits is the zero count of the data field alone. When that count is nonzero, the block then overwrites every data byte in the sector buffer with all-ones through a plain RAM write port. If the sum is above the limit, the sector is reported uncorrectable. A single-cycle done pulse carries the verdict, and it comes only after any buffer rewrite has finished.

Top module: `esz_erase_detect`

## Requirements
- R1: After reset, in_ready_o, done_o and buf_we_o are all 0.
- R2: A start_i pulse in the idle state begins a check only if dec_err_i is greater than LIMIT (default 8). A start with dec_err_i of LIMIT or less is ignored: in_ready_o stays 0 and no done_o follows.
- R3: While a check runs, in_ready_o is 1. A beat is accepted when in_valid_i and in_ready_o are both 1. The first field is the data field and the second is the check field, and each ends on the beat that carries in_last_i = 1. Beats with in_valid_i = 0 are skipped.
- R4: Each accepted byte adds the number of its zero bits to the count of its field. Each count saturates at LIMIT+1, so it never wraps, even for a field that is all 0x00.
- R5: At the end of the check field, the sector is erased when the data count plus the check count is LIMIT or less, and uncorrectable otherwise. Exactly one of erased_o and uncorr_o is 1 while done_o is 1.
- R6: For an erased sector, flips_o equals the data-field zero count. Zeros in the check field do not add to it. For an uncorrectable sector, flips_o is 0.
- R7: For an erased sector with a nonzero data count, the block writes 0xFF to buffer addresses 0 through DATA_BYTES-1. It writes one address per cycle, in ascending order, with no gaps, and in_ready_o is 0 during the writes.
- R8: For an erased sector with a data count of zero, no buffer write occurs, and done_o is 1 in the cycle after the last check byte is accepted.
- R9: When there is a fill, done_o is 1 in the cycle after the last buffer write. done_o lasts exactly one cycle. erased_o, uncorr_o and flips_o then hold their values until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a check (single-cycle pulse) |
| dec_err_i | input | ERR_W | Error count reported by the decoder |
| in_valid_i | input | 1 | Byte beat valid |
| in_ready_o | output | 1 | Block accepts a byte beat |
| in_byte_i | input | 8 | Byte of the data or check field |
| in_last_i | input | 1 | Marks the last byte of the current field |
| buf_we_o | output | 1 | Sector buffer write enable |
| buf_addr_o | output | ADDR_W | Sector buffer byte address |
| buf_wdata_o | output | 8 | Sector buffer write data |
| done_o | output | 1 | Verdict valid (single-cycle pulse) |
| erased_o | output | 1 | Sector treated as erased |
| uncorr_o | output | 1 | Sector is uncorrectable |
| flips_o | output | CNT_W | Zero bits found in the data field |

## Verification
The bench builds the block with a 16-byte data field and keeps the limit at 8, with 13 check bytes per stream. The short field keeps each full rewrite to 16 cycles, so every scenario can trace the write sequence address by address and place the done pulse exactly. A 16-byte all-zero data field holds 128 zero bits, and 13 all-zero check bytes hold 104. Both totals would wrap a 4-bit counter to a value at or under the limit, so saturation is exercised in both fields. The bench also covers the 8-versus-9 boundary, a zero that lands only in the check field, and gaps in the valid stream.

// File: rtl/esz_pkg.sv
package esz_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_DATA  = 2'd1,
        ST_CHECK = 2'd2,
        ST_FILL  = 2'd3
    } esz_state_e;

    // number of bits at zero in one byte
    function automatic logic [3:0] zero_bits(input logic [7:0] b);
        logic [3:0] n;
        n = 4'd0;
        for (int i = 0; i < 8; i++) begin
            n = n + {3'd0, ~b[i]};
        end
        return n;
    endfunction

endpackage

// File: rtl/esz_zero_counter.sv
module esz_zero_counter #(
    parameter int LIMIT = 8,
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             add_i,
    input  logic [7:0]       byte_i,
    output logic [CNT_W-1:0] total_o
);
    import esz_pkg::*;

    localparam int SUM_W = CNT_W + 4;
    localparam logic [SUM_W-1:0] SAT = SUM_W'(LIMIT + 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic [SUM_W-1:0] sum;

    always_comb begin
        cnt_d = cnt_q;
        sum   = SUM_W'(cnt_q) + SUM_W'(zero_bits(byte_i));
        if (clear_i) begin
            cnt_d = '0;
        end else if (add_i) begin
            cnt_d = (sum > SAT) ? SAT[CNT_W-1:0] : sum[CNT_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // count including the beat accepted this cycle
    assign total_o = cnt_d;

endmodule

// File: rtl/esz_fill_seq.sv
module esz_fill_seq #(
    parameter int DEPTH = 512,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go_i,
    output logic              we_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [7:0]        wdata_o,
    output logic              last_o
);
    localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(DEPTH - 1);

    typedef struct packed {
        logic              busy;
        logic [ADDR_W-1:0] addr;
    } fill_st_t;

    fill_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.busy) begin
            if (st_q.addr == LAST_ADDR) begin
                st_d.busy = 1'b0;
                st_d.addr = '0;
            end else begin
                st_d.addr = st_q.addr + 1'b1;
            end
        end else if (go_i) begin
            st_d.busy = 1'b1;
            st_d.addr = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign we_o    = st_q.busy;
    assign addr_o  = st_q.addr;
    assign wdata_o = 8'hFF;
    assign last_o  = st_q.busy && (st_q.addr == LAST_ADDR);

endmodule

// File: rtl/esz_erase_detect.sv
module esz_erase_detect #(
    parameter int DATA_BYTES = 512,
    parameter int LIMIT      = 8,
    parameter int ERR_W      = 4,
    localparam int CNT_W     = $clog2(LIMIT + 2),
    localparam int ADDR_W    = $clog2(DATA_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ERR_W-1:0]  dec_err_i,
    input  logic              in_valid_i,
    output logic              in_ready_o,
    input  logic [7:0]        in_byte_i,
    input  logic              in_last_i,
    output logic              buf_we_o,
    output logic [ADDR_W-1:0] buf_addr_o,
    output logic [7:0]        buf_wdata_o,
    output logic              done_o,
    output logic              erased_o,
    output logic              uncorr_o,
    output logic [CNT_W-1:0]  flips_o
);
    import esz_pkg::*;

    localparam int NFIELD = 2;   // 0: data field, 1: check field
    localparam int SUM_W  = CNT_W + 1;

    typedef struct packed {
        esz_state_e       state;
        logic             erased;
        logic             uncorr;
        logic [CNT_W-1:0] flips;
        logic             done;
    } top_st_t;

    top_st_t st_d, st_q;

    logic             start_ok;
    logic             accept;
    logic             fill_go;
    logic             fill_last;
    logic [NFIELD-1:0] add_en;
    logic [CNT_W-1:0] field_cnt [NFIELD];
    logic [SUM_W-1:0] total;

    assign in_ready_o = (st_q.state == ST_DATA) || (st_q.state == ST_CHECK);
    assign accept     = in_valid_i && in_ready_o;
    assign start_ok   = start_i && (st_q.state == ST_IDLE) && (int'(dec_err_i) > LIMIT);
    assign add_en[0]  = accept && (st_q.state == ST_DATA);
    assign add_en[1]  = accept && (st_q.state == ST_CHECK);

    for (genvar f = 0; f < NFIELD; f++) begin : g_field
        esz_zero_counter #(
            .LIMIT (LIMIT),
            .CNT_W (CNT_W)
        ) u_cnt (
            .clk     (clk),
            .rst_n   (rst_n),
            .clear_i (start_ok),
            .add_i   (add_en[f]),
            .byte_i  (in_byte_i),
            .total_o (field_cnt[f])
        );
    end

    assign total = SUM_W'(field_cnt[0]) + SUM_W'(field_cnt[1]);

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        fill_go   = 1'b0;
        unique case (st_q.state)
            ST_IDLE: begin
                if (start_ok) begin
                    st_d.state  = ST_DATA;
                    st_d.erased = 1'b0;
                    st_d.uncorr = 1'b0;
                    st_d.flips  = '0;
                end
            end
            ST_DATA: begin
                if (accept && in_last_i) st_d.state = ST_CHECK;
            end
            ST_CHECK: begin
                if (accept && in_last_i) begin
                    if (total <= SUM_W'(LIMIT)) begin
                        st_d.erased = 1'b1;
                        st_d.flips  = field_cnt[0];
                        if (field_cnt[0] != '0) begin
                            st_d.state = ST_FILL;
                            fill_go    = 1'b1;
                        end else begin
                            st_d.state = ST_IDLE;
                            st_d.done  = 1'b1;
                        end
                    end else begin
                        st_d.uncorr = 1'b1;
                        st_d.flips  = '0;
                        st_d.state  = ST_IDLE;
                        st_d.done   = 1'b1;
                    end
                end
            end
            ST_FILL: begin
                if (fill_last) begin
                    st_d.state = ST_IDLE;
                    st_d.done  = 1'b1;
                end
            end
            default: st_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{state: ST_IDLE, default: '0};
        else        st_q <= st_d;
    end

    esz_fill_seq #(
        .DEPTH (DATA_BYTES)
    ) u_fill (
        .clk     (clk),
        .rst_n   (rst_n),
        .go_i    (fill_go),
        .we_o    (buf_we_o),
        .addr_o  (buf_addr_o),
        .wdata_o (buf_wdata_o),
        .last_o  (fill_last)
    );

    assign done_o   = st_q.done;
    assign erased_o = st_q.erased;
    assign uncorr_o = st_q.uncorr;
    assign flips_o  = st_q.flips;

endmodule

// File: rtl/esz_erase_detect_chk.sv
module esz_erase_detect_chk #(
    parameter int DATA_BYTES = 512,
    parameter int LIMIT      = 8,
    parameter int ERR_W      = 4,
    localparam int CNT_W     = $clog2(LIMIT + 2),
    localparam int ADDR_W    = $clog2(DATA_BYTES)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic [ERR_W-1:0]  dec_err_i,
    input logic              in_ready_o,
    input logic              buf_we_o,
    input logic [ADDR_W-1:0] buf_addr_o,
    input logic [7:0]        buf_wdata_o,
    input logic              done_o,
    input logic              erased_o,
    input logic              uncorr_o,
    input logic [CNT_W-1:0]  flips_o
);
    localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(DATA_BYTES - 1);

    AST_IGNORE_LOW_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_ready_o && !buf_we_o && start_i && int'(dec_err_i) <= LIMIT) |=> !in_ready_o); // R2
    AST_START_HIGH_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_ready_o && !buf_we_o && start_i && int'(dec_err_i) > LIMIT) |=> in_ready_o); // R2
    AST_VERDICT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (erased_o ^ uncorr_o)); // R5
    AST_FLIPS_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && erased_o) |-> (int'(flips_o) <= LIMIT)); // R6
    AST_UNCORR_NO_FLIPS: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && uncorr_o) |-> (flips_o == '0)); // R6
    AST_FILL_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        buf_we_o |-> (buf_wdata_o == 8'hFF)); // R7
    AST_FILL_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_we_o && !$past(buf_we_o)) |-> (buf_addr_o == '0)); // R7
    AST_FILL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_we_o && $past(buf_we_o)) |-> (buf_addr_o == ADDR_W'($past(buf_addr_o) + 1'b1))); // R7
    AST_FILL_NO_STREAM: assert property (@(posedge clk) disable iff (!rst_n)
        buf_we_o |-> !in_ready_o); // R7
    AST_DONE_AFTER_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && erased_o && flips_o != '0) |-> ($past(buf_we_o) && $past(buf_addr_o) == LAST_ADDR)); // R9
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R9

endmodule

bind esz_erase_detect esz_erase_detect_chk #(
    .DATA_BYTES (DATA_BYTES),
    .LIMIT      (LIMIT),
    .ERR_W      (ERR_W)
) u_chk (.*);

// File: tb/esz_erase_detect_test.sv
module esz_erase_detect_test;

    localparam int DB    = 16;
    localparam int NC    = 13;
    localparam int LIM   = 8;
    localparam int ERR_W = 4;
    localparam int CNT_W = $clog2(LIM + 2);
    localparam int AW    = $clog2(DB);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start_i = 1'b0;
    logic [ERR_W-1:0] dec_err_i = '0;
    logic             in_valid_i = 1'b0;
    logic             in_ready_o;
    logic [7:0]       in_byte_i = 8'hFF;
    logic             in_last_i = 1'b0;
    logic             buf_we_o;
    logic [AW-1:0]    buf_addr_o;
    logic [7:0]       buf_wdata_o;
    logic             done_o;
    logic             erased_o;
    logic             uncorr_o;
    logic [CNT_W-1:0] flips_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    logic [7:0] dbuf [DB];
    logic [7:0] cbuf [NC];

    always #5 clk = ~clk;

    esz_erase_detect #(
        .DATA_BYTES (DB),
        .LIMIT      (LIM),
        .ERR_W      (ERR_W)
    ) uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .dec_err_i   (dec_err_i),
        .in_valid_i  (in_valid_i),
        .in_ready_o  (in_ready_o),
        .in_byte_i   (in_byte_i),
        .in_last_i   (in_last_i),
        .buf_we_o    (buf_we_o),
        .buf_addr_o  (buf_addr_o),
        .buf_wdata_o (buf_wdata_o),
        .done_o      (done_o),
        .erased_o    (erased_o),
        .uncorr_o    (uncorr_o),
        .flips_o     (flips_o)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic clear_pattern();
        for (int i = 0; i < DB; i++) dbuf[i] = 8'hFF;
        for (int i = 0; i < NC; i++) cbuf[i] = 8'hFF;
    endtask

    task automatic send_byte(input logic [7:0] b, input logic last);
        @(negedge clk);
        in_valid_i = 1'b1;
        in_byte_i  = b;
        in_last_i  = last;
    endtask

    // one complete check; gap inserts idle beats inside the data field
    task automatic run_sector(input string req, input bit exp_erased,
                              input int exp_flips, input bit gap);
        bit fill_exp;
        int writes, bad_addr, bad_data, done_at, done_cnt;
        logic got_erased, got_uncorr;
        logic [CNT_W-1:0] got_flips;
        fill_exp = exp_erased && (exp_flips != 0);
        writes = 0; bad_addr = 0; bad_data = 0; done_at = 0; done_cnt = 0;
        got_erased = 1'b0; got_uncorr = 1'b0; got_flips = '0;
        @(negedge clk);
        start_i   = 1'b1;
        dec_err_i = 4'd12;
        @(negedge clk);
        start_i = 1'b0;
        check(in_ready_o == 1'b1, "R2", {req, " ready after start"}, int'(in_ready_o), 1);
        for (int i = 0; i < DB; i++) begin
            if (gap && (i == 3 || i == 9)) begin
                @(negedge clk);
                in_valid_i = 1'b0;
                in_byte_i  = 8'h00;
                in_last_i  = 1'b1;
            end
            send_byte(dbuf[i], i == DB - 1);
        end
        for (int i = 0; i < NC; i++) send_byte(cbuf[i], i == NC - 1);
        for (int k = 1; k <= DB + 4; k++) begin
            @(negedge clk);
            if (k == 1) begin
                in_valid_i = 1'b0;
                in_last_i  = 1'b0;
                in_byte_i  = 8'hFF;
            end
            if (buf_we_o) begin
                if (int'(buf_addr_o) != writes) bad_addr++;
                if (buf_wdata_o != 8'hFF) bad_data++;
                writes++;
            end
            if (done_o) begin
                done_cnt++;
                if (done_at == 0) begin
                    done_at    = k;
                    got_erased = erased_o;
                    got_uncorr = uncorr_o;
                    got_flips  = flips_o;
                end
            end
        end
        check(done_cnt == 1, "R9", {req, " done pulses"}, done_cnt, 1);
        check(got_erased == exp_erased, "R5", {req, " erased"}, int'(got_erased), int'(exp_erased));
        check(got_uncorr == !exp_erased, "R5", {req, " uncorrectable"}, int'(got_uncorr), int'(!exp_erased));
        check(int'(got_flips) == exp_flips, "R6", {req, " flips"}, int'(got_flips), exp_flips);
        check(writes == (fill_exp ? DB : 0), fill_exp ? "R7" : "R8", {req, " buffer writes"},
              writes, fill_exp ? DB : 0);
        check(bad_addr == 0, "R7", {req, " write address order"}, bad_addr, 0);
        check(bad_data == 0, "R7", {req, " write data"}, bad_data, 0);
        check(done_at == (fill_exp ? DB + 1 : 1), fill_exp ? "R9" : "R8", {req, " done cycle"},
              done_at, fill_exp ? DB + 1 : 1);
        check(erased_o == got_erased && flips_o == got_flips, "R9", {req, " result held"},
              int'(flips_o), int'(got_flips));
    endtask

    task automatic t_reset();
        check(in_ready_o == 1'b0, "R1", "ready in reset state", int'(in_ready_o), 0);
        check(done_o == 1'b0, "R1", "done in reset state", int'(done_o), 0);
        check(buf_we_o == 1'b0, "R1", "write enable in reset state", int'(buf_we_o), 0);
    endtask

    task automatic t_ignore_low(input logic [ERR_W-1:0] err);
        int seen_ready, seen_done;
        seen_ready = 0; seen_done = 0;
        @(negedge clk);
        start_i   = 1'b1;
        dec_err_i = err;
        @(negedge clk);
        start_i = 1'b0;
        for (int k = 0; k < 4; k++) begin
            if (in_ready_o) seen_ready++;
            if (done_o) seen_done++;
            @(negedge clk);
        end
        check(seen_ready == 0, "R2", "ready after low-error start", seen_ready, 0);
        check(seen_done == 0, "R2", "done after low-error start", seen_done, 0);
    endtask

    task automatic t_all_ones();
        clear_pattern();
        run_sector("R8 all-ones", 1'b1, 0, 1'b0);
    endtask

    task automatic t_few_flips();
        clear_pattern();
        dbuf[0]  = 8'hFE;
        dbuf[15] = 8'h3F;
        cbuf[0]  = 8'h7F;
        cbuf[5]  = 8'hFB;
        run_sector("R6 three data two check", 1'b1, 3, 1'b0);
    endtask

    task automatic t_boundary_8();
        clear_pattern();
        dbuf[2]  = 8'hE0;
        cbuf[12] = 8'hF8;
        run_sector("R5 total eight", 1'b1, 5, 1'b0);
    endtask

    task automatic t_boundary_9();
        clear_pattern();
        dbuf[2]  = 8'hE0;
        cbuf[12] = 8'hF0;
        run_sector("R5 total nine", 1'b0, 0, 1'b0);
    endtask

    task automatic t_check_only();
        clear_pattern();
        dbuf[4] = 8'hEF;
        cbuf[3] = 8'h01;
        run_sector("R6 check zeros excluded", 1'b1, 1, 1'b0);
    endtask

    task automatic t_data_nine();
        clear_pattern();
        dbuf[0] = 8'h00;
        dbuf[1] = 8'hFE;
        run_sector("R4 data nine", 1'b0, 0, 1'b0);
    endtask

    task automatic t_sat_data();
        for (int i = 0; i < DB; i++) dbuf[i] = 8'h00;
        for (int i = 0; i < NC; i++) cbuf[i] = 8'hFF;
        run_sector("R4 data all zero", 1'b0, 0, 1'b0);
    endtask

    task automatic t_sat_check();
        for (int i = 0; i < DB; i++) dbuf[i] = 8'hFF;
        for (int i = 0; i < NC; i++) cbuf[i] = 8'h00;
        run_sector("R4 check all zero", 1'b0, 0, 1'b0);
    endtask

    task automatic t_gaps();
        clear_pattern();
        dbuf[7] = 8'h7E;
        run_sector("R3 valid gaps", 1'b1, 2, 1'b1);
    endtask

    initial begin
        #(200000 * 10);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_ignore_low(4'd8);
        t_ignore_low(4'd0);
        t_all_ones();
        t_few_flips();
        t_boundary_8();
        t_boundary_9();
        t_check_only();
        t_data_nine();
        t_sat_data();
        t_sat_check();
        t_gaps();
        t_ignore_low(4'd3);
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule